// File: doc/BRIEF.md
# USB Port Link-State Monitor

This block watches the already-decoded line conditions of a USB 2.0 port and drives two status flags. The first, `conn_flag`, says that a device is attached. The second, `hs_flag`, says that the channel runs at high speed. Its inputs are synchronous one-bit indications from the analog front end: pull-up seen, disconnect, SE0 (bus reset), chirp J, chirp K, squelch, test-fixture present and test packet seen. A microsecond strobe (`us_tick`) times the chirps and the enable pulses. An active-low enable (`port_en`) puts the block into shutdown. A hold input (`cfg_hold`) freezes the state machine while configuration is under way.

The controller is a single enumerated state machine with ten states:

| State | Meaning | conn_flag | hs_flag |
|---|---|---|---|
| ST_DISC | disconnected | 0 | 0 |
| ST_FIXTURE | test fixture seen, waiting for a test packet | 0 | 0 |
| ST_LSFS | low- or full-speed | 1 | 0 |
| ST_BUSRST | bus reset in progress | 1 | 0 |
| ST_CHIRP_J | chirp J being timed | 1 | 0 |
| ST_CHIRP_K | chirp K being timed | 1 | 0 |
| ST_HS_ARMED | valid pair seen, waiting for squelch | 1 | 0 |
| ST_HS_ACTIVE | high-speed active | 1 | 1 |
| ST_COMPLIANCE | compliance-test mode | 0 | 1 |
| ST_SHUTDOWN | qualified shutdown and wake-up | 0 | 0 |

Transitions:

- **Attach.** DISC goes to LSFS on a pull-up. DISC goes to FIXTURE on a fixture; the fixture wins if both are present.
- **Test path.** FIXTURE goes to COMPLIANCE on a test packet, and back to DISC if the fixture goes away.
- **Handshake.** LSFS goes to BUSRST on SE0. BUSRST goes to CHIRP_J when chirp J begins. From CHIRP_J the machine goes to CHIRP_K, and from CHIRP_K to HS_ARMED, each time only when the chirp just ended lasted inside the window. Any other exit from BUSRST, CHIRP_J or CHIRP_K falls back to LSFS. HS_ARMED goes to HS_ACTIVE on squelch.
- **Detach.** A disconnect in any other state returns the machine to DISC.
- **Shutdown.** A qualified shutdown moves any state to SHUTDOWN. After the wake-up time, SHUTDOWN leaves for COMPLIANCE if it was entered from HS_ACTIVE, and for DISC otherwise.

Top module: `usb_link_monitor`

## Requirements
- R1: After reset both flags are low (state ST_DISC). A pull-up detection from ST_DISC gives conn_flag=1 and hs_flag=0 (low/full-speed).
- R2: A disconnect in any connected state, including high-speed active and compliance-test, returns the block to ST_DISC with both flags low on the next cycle.
- R3: SE0, then one chirp J, then one chirp K, each chirp lasting 18 to 128 µs, then squelch, gives conn_flag=1 and hs_flag=1.
- R4: If either chirp of the pair lasts less than 18 µs or more than 128 µs, the port stays low/full-speed (1,0), and a later squelch does not raise hs_flag.
- R5: A chirp K seen before any chirp J during bus reset leaves the port low/full-speed (1,0).
- R6: The chirp duration count restarts on every line-state change and saturates above 128 µs. A chirp of 300 µs is therefore rejected and not mistaken for a short one.
- R7: A test fixture seen in ST_DISC, followed by a test packet, gives conn_flag=0 and hs_flag=1.
- R8: While port_en is low both flags are low. A low pulse shorter than 100 µs leaves the state unchanged, and the flags return to their previous values once port_en is high.
- R9: A low pulse of at least 100 µs is a valid shutdown. The block restarts in ST_DISC after port_en rises, within 500 µs (parameter READY_US, default 300 µs), with both flags low until then.
- R10: A valid shutdown pulse taken while in high-speed active makes the block re-enter in compliance-test mode (conn_flag=0, hs_flag=1).
- R11: While cfg_hold is high the state, and so the flags, do not change, even on a disconnect. A qualified shutdown still overrides the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| port_en | input | 1 | Enable; low requests shutdown |
| cfg_hold | input | 1 | Freezes the state machine while high |
| pullup_det | input | 1 | Pull-up detected on either data line |
| disc_det | input | 1 | Disconnect detected |
| se0_det | input | 1 | SE0 (bus reset) on the line |
| chirp_j | input | 1 | Chirp J on the line |
| chirp_k | input | 1 | Chirp K on the line |
| squelch | input | 1 | Squelch detected |
| fixture_det | input | 1 | Compliance test fixture present |
| test_pkt | input | 1 | Test packet pattern seen |
| conn_flag | output | 1 | Connection detected |
| hs_flag | output | 1 | High-speed mode active |

## Verification
The in-line properties check on every cycle that:
- both flags are low while enable is low;
- a disconnect always lands in ST_DISC;
- hold keeps the state stable;
- high-speed active is reachable only from the armed state;
- the chirp count never passes its saturation value;
- an enable that stays high never starts a shutdown;
- the wake-up counter stays within its bound;
- compliance mode always shows the (0,1) flag pair.

Only the directed scenarios can show the timing-dependent outcomes:
- chirps accepted inside the window and rejected outside it, including a 300 µs chirp that a wrapping counter would accept;
- a short enable glitch leaving the state untouched;
- the wake-up delay;
- the re-entry into compliance mode after a pulse taken at high speed.

// File: rtl/usb_lmon_pkg.sv
package usb_lmon_pkg;

    typedef enum logic [3:0] {
        ST_DISC,
        ST_FIXTURE,
        ST_LSFS,
        ST_BUSRST,
        ST_CHIRP_J,
        ST_CHIRP_K,
        ST_HS_ARMED,
        ST_HS_ACTIVE,
        ST_COMPLIANCE,
        ST_SHUTDOWN
    } lmon_state_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_SE0,
        LN_J,
        LN_K
    } lmon_line_e;

endpackage

// File: rtl/lmon_dur_timer.sv
// Measures how long the current line condition has lasted, in microseconds.
module lmon_dur_timer
    import usb_lmon_pkg::*;
#(
    parameter int SAT_US = 129,
    localparam int DW = $clog2(SAT_US + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  lmon_line_e       line_now,
    output logic [DW-1:0]    dur_us
);
    localparam logic [DW-1:0] SAT_L = DW'(SAT_US);

    lmon_line_e    line_q;
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= LN_IDLE;
            cnt_q  <= '0;
        end else begin
            line_q <= line_now;
            if (line_now != line_q) begin
                cnt_q <= '0;
            end else if (us_tick && cnt_q < SAT_L) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign dur_us = cnt_q;

    // R6: the count stops at its saturation value
    p_count_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_L);

endmodule

// File: rtl/lmon_en_filter.sv
// Qualifies enable-low pulses and holds shutdown through the wake-up time.
module lmon_en_filter #(
    parameter int MIN_LOW_US = 100,
    parameter int READY_US   = 300,
    localparam int LW = $clog2(MIN_LOW_US + 1),
    localparam int WW = $clog2(READY_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic port_en,
    output logic sd_active
);
    localparam logic [LW-1:0] MIN_L = LW'(MIN_LOW_US);
    localparam logic [WW-1:0] RDY_L = WW'(READY_US);

    logic [LW-1:0] low_cnt_q;
    logic [WW-1:0] wake_cnt_q;
    logic          sd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q  <= '0;
            wake_cnt_q <= '0;
            sd_q       <= 1'b0;
        end else if (!port_en) begin
            wake_cnt_q <= '0;
            if (us_tick && low_cnt_q < MIN_L) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
            if (low_cnt_q >= MIN_L) begin
                sd_q <= 1'b1;
            end
        end else begin
            low_cnt_q <= '0;
            if (sd_q) begin
                if (wake_cnt_q >= RDY_L) begin
                    sd_q       <= 1'b0;
                    wake_cnt_q <= '0;
                end else if (us_tick) begin
                    wake_cnt_q <= wake_cnt_q + 1'b1;
                end
            end
        end
    end

    assign sd_active = sd_q;

    // R8: with enable high, no new shutdown can start
    p_short_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_q && port_en) |=> !sd_q);

    // R9: the wake-up wait never exceeds its bound
    p_wake_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_cnt_q <= RDY_L);

endmodule

// File: rtl/lmon_flag_decode.sv
// Moore decode of the status flags from the state, gated by the enable.
module lmon_flag_decode
    import usb_lmon_pkg::*;
(
    input  lmon_state_e state,
    input  logic        port_en,
    output logic        conn_flag,
    output logic        hs_flag
);
    always_comb begin
        conn_flag = 1'b0;
        hs_flag   = 1'b0;
        unique case (state)
            ST_DISC, ST_FIXTURE, ST_SHUTDOWN: begin
                conn_flag = 1'b0;
                hs_flag   = 1'b0;
            end
            ST_LSFS, ST_BUSRST, ST_CHIRP_J, ST_CHIRP_K, ST_HS_ARMED: begin
                conn_flag = 1'b1;
                hs_flag   = 1'b0;
            end
            ST_HS_ACTIVE: begin
                conn_flag = 1'b1;
                hs_flag   = 1'b1;
            end
            ST_COMPLIANCE: begin
                conn_flag = 1'b0;
                hs_flag   = 1'b1;
            end
            default: begin
                conn_flag = 1'b0;
                hs_flag   = 1'b0;
            end
        endcase
        if (!port_en) begin
            conn_flag = 1'b0;
            hs_flag   = 1'b0;
        end
    end
endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
    import usb_lmon_pkg::*;
#(
    parameter int CHIRP_MIN_US = 18,
    parameter int CHIRP_MAX_US = 128,
    parameter int MIN_LOW_US   = 100,
    parameter int READY_US     = 300,
    localparam int SAT_US = CHIRP_MAX_US + 1,
    localparam int DW     = $clog2(SAT_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic port_en,
    input  logic cfg_hold,
    input  logic pullup_det,
    input  logic disc_det,
    input  logic se0_det,
    input  logic chirp_j,
    input  logic chirp_k,
    input  logic squelch,
    input  logic fixture_det,
    input  logic test_pkt,
    output logic conn_flag,
    output logic hs_flag
);
    localparam logic [DW-1:0] WIN_LO = DW'(CHIRP_MIN_US);
    localparam logic [DW-1:0] WIN_HI = DW'(CHIRP_MAX_US);

    lmon_state_e   state_q, state_d;
    logic          resume_cmp_q;
    lmon_line_e    line_now;
    logic [DW-1:0] dur_us;
    logic          sd_active;
    logic          chirp_ok;

    always_comb begin
        if (chirp_j)      line_now = LN_J;
        else if (chirp_k) line_now = LN_K;
        else if (se0_det) line_now = LN_SE0;
        else              line_now = LN_IDLE;
    end

    lmon_dur_timer #(.SAT_US(SAT_US)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .line_now (line_now),
        .dur_us   (dur_us)
    );

    lmon_en_filter #(.MIN_LOW_US(MIN_LOW_US), .READY_US(READY_US)) u_enf (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .port_en   (port_en),
        .sd_active (sd_active)
    );

    assign chirp_ok = (dur_us >= WIN_LO) && (dur_us <= WIN_HI);

    always_comb begin
        state_d = state_q;
        if (sd_active) begin
            state_d = ST_SHUTDOWN;
        end else if (state_q == ST_SHUTDOWN) begin
            state_d = resume_cmp_q ? ST_COMPLIANCE : ST_DISC;
        end else if (cfg_hold) begin
            state_d = state_q;
        end else if (disc_det) begin
            state_d = ST_DISC;
        end else begin
            unique case (state_q)
                ST_DISC: begin
                    if (fixture_det)     state_d = ST_FIXTURE;
                    else if (pullup_det) state_d = ST_LSFS;
                end
                ST_FIXTURE: begin
                    if (test_pkt)         state_d = ST_COMPLIANCE;
                    else if (!fixture_det) state_d = ST_DISC;
                end
                ST_LSFS: begin
                    if (se0_det) state_d = ST_BUSRST;
                end
                ST_BUSRST: begin
                    if (line_now == LN_J)        state_d = ST_CHIRP_J;
                    else if (line_now != LN_SE0) state_d = ST_LSFS;
                end
                ST_CHIRP_J: begin
                    if (line_now != LN_J) begin
                        state_d = (line_now == LN_K && chirp_ok) ? ST_CHIRP_K : ST_LSFS;
                    end
                end
                ST_CHIRP_K: begin
                    if (line_now != LN_K) begin
                        state_d = chirp_ok ? ST_HS_ARMED : ST_LSFS;
                    end
                end
                ST_HS_ARMED: begin
                    if (squelch) state_d = ST_HS_ACTIVE;
                end
                ST_HS_ACTIVE:  state_d = ST_HS_ACTIVE;
                ST_COMPLIANCE: state_d = ST_COMPLIANCE;
                default:       state_d = ST_DISC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_DISC;
            resume_cmp_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sd_active && state_q != ST_SHUTDOWN) begin
                resume_cmp_q <= (state_q == ST_HS_ACTIVE);
            end
        end
    end

    lmon_flag_decode u_dec (
        .state     (state_q),
        .port_en   (port_en),
        .conn_flag (conn_flag),
        .hs_flag   (hs_flag)
    );

    // R8: enable low forces both flags low
    p_flags_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (!conn_flag && !hs_flag));

    // R2: a disconnect lands in the disconnected state
    p_disc_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_det && !sd_active && !cfg_hold && state_q != ST_SHUTDOWN)
        |=> state_q == ST_DISC);

    // R11: hold freezes the state
    p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hold && !sd_active && state_q != ST_SHUTDOWN) |=> $stable(state_q));

    // R3: high-speed active is entered only from the armed state
    p_hs_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HS_ARMED && state_q != ST_HS_ACTIVE) |=> state_q != ST_HS_ACTIVE);

    // R7: compliance mode shows connection low, high-speed high
    p_cmp_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPLIANCE && port_en) |-> (!conn_flag && hs_flag));

endmodule

// File: tb/tb_usb_link_monitor.sv
module tb_usb_link_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic port_en = 1'b1;
    logic cfg_hold = 1'b0;
    logic pullup_det = 1'b0, disc_det = 1'b0, se0_det = 1'b0;
    logic chirp_j = 1'b0, chirp_k = 1'b0, squelch = 1'b0;
    logic fixture_det = 1'b0, test_pkt = 1'b0;
    logic conn_flag, hs_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;                       // 50 MHz
    always @(posedge clk) us_tick <= ~us_tick;   // 1 µs = 2 cycles

    usb_link_monitor dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .port_en(port_en),
        .cfg_hold(cfg_hold), .pullup_det(pullup_det), .disc_det(disc_det),
        .se0_det(se0_det), .chirp_j(chirp_j), .chirp_k(chirp_k),
        .squelch(squelch), .fixture_det(fixture_det), .test_pkt(test_pkt),
        .conn_flag(conn_flag), .hs_flag(hs_flag)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic ec, input logic eh);
        n_chk++;
        if (conn_flag !== ec || hs_flag !== eh) begin
            n_fail++;
            $display("FAIL %s: conn/hs actual %b%b expected %b%b", req, conn_flag, hs_flag, ec, eh);
        end
    endtask

    task automatic pulse_pullup();
        pullup_det = 1'b1; step(1); pullup_det = 1'b0; step(1);
    endtask

    task automatic pulse_disc();
        disc_det = 1'b1; step(1); disc_det = 1'b0; step(1);
    endtask

    // bus reset then chirp J (jus µs), chirp K (kus µs), then squelch
    task automatic handshake(input int jus, input int kus);
        se0_det = 1'b1; step(20);
        se0_det = 1'b0; chirp_j = 1'b1; step(2 * jus);
        chirp_j = 1'b0; chirp_k = 1'b1; step(2 * kus);
        chirp_k = 1'b0; step(2);
        squelch = 1'b1; step(2); squelch = 1'b0; step(1);
    endtask

    task automatic t_reset_r1();
        chk("R1 reset", 1'b0, 1'b0);
        pulse_pullup();
        chk("R1 lsfs attach", 1'b1, 1'b0);
    endtask

    task automatic t_hs_good_r3();
        handshake(50, 50);
        chk("R3 hs after valid pair", 1'b1, 1'b1);
        pulse_disc();
        chk("R2 disconnect from hs", 1'b0, 1'b0);
    endtask

    task automatic t_window_r4();
        pulse_pullup();
        handshake(5, 50);
        chk("R4 short J rejected", 1'b1, 1'b0);
        handshake(50, 200);
        chk("R4 long K rejected", 1'b1, 1'b0);
        pulse_disc();
    endtask

    task automatic t_sat_r6();
        pulse_pullup();
        handshake(300, 50);
        chk("R6 300us J rejected", 1'b1, 1'b0);
        pulse_disc();
        chk("R2 disconnect from lsfs", 1'b0, 1'b0);
    endtask

    task automatic t_order_r5();
        pulse_pullup();
        se0_det = 1'b1; step(20);
        se0_det = 1'b0; chirp_k = 1'b1; step(100);
        chirp_k = 1'b0; chirp_j = 1'b1; step(100);
        chirp_j = 1'b0; step(2);
        squelch = 1'b1; step(2); squelch = 1'b0; step(1);
        chk("R5 K before J", 1'b1, 1'b0);
        pulse_disc();
    endtask

    task automatic t_compliance_r7();
        fixture_det = 1'b1; step(2);
        chk("R7 fixture wait", 1'b0, 1'b0);
        test_pkt = 1'b1; step(1); test_pkt = 1'b0; fixture_det = 1'b0; step(1);
        chk("R7 compliance flags", 1'b0, 1'b1);
        pulse_disc();
        chk("R2 disconnect from compliance", 1'b0, 1'b0);
    endtask

    task automatic t_glitch_r8();
        pulse_pullup();
        port_en = 1'b0; step(2);
        chk("R8 flags low while enable low", 1'b0, 1'b0);
        step(78);
        port_en = 1'b1; step(2);
        chk("R8 short pulse ignored", 1'b1, 1'b0);
    endtask

    task automatic t_shutdown_r9();
        port_en = 1'b0; step(300);
        port_en = 1'b1; step(10);
        chk("R9 low during wake", 1'b0, 1'b0);
        step(1000);
        chk("R9 restart disconnected", 1'b0, 1'b0);
        pulse_pullup();
        chk("R9 ready after wake", 1'b1, 1'b0);
        pulse_disc();
    endtask

    task automatic t_hs_pulse_r10();
        pulse_pullup();
        handshake(40, 40);
        chk("R10 hs before pulse", 1'b1, 1'b1);
        port_en = 1'b0; step(300);
        port_en = 1'b1; step(1010);
        chk("R10 compliance re-entry", 1'b0, 1'b1);
        pulse_disc();
    endtask

    task automatic t_hold_r11();
        pulse_pullup();
        cfg_hold = 1'b1; step(1);
        pulse_disc();
        chk("R11 hold ignores disconnect", 1'b1, 1'b0);
        cfg_hold = 1'b0; step(2);
        chk("R11 state kept after hold", 1'b1, 1'b0);
        pulse_disc();
        chk("R11 disconnect after hold", 1'b0, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset_r1();
        pulse_disc();
        pulse_pullup();
        t_hs_good_r3();
        t_window_r4();
        t_sat_r6();
        t_order_r5();
        t_compliance_r7();
        t_glitch_r8();
        pulse_disc();
        t_shutdown_r9();
        t_hs_pulse_r10();
        t_hold_r11();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule